// File: doc/BRIEF.md
# Serial EEPROM Page Write Engine

This block sits behind the bit-level front-end of a two-wire serial EEPROM. It takes one write transfer's word address and data bytes and holds them in a page buffer. Each data byte goes to the buffer slot picked by a 4-bit in-page pointer. The pointer advances after every byte and wraps inside the page, while the page row stays where the word address put it.

When the front-end reports a stop condition and at least one byte has been buffered, the engine enters a timed programming cycle. In that cycle it writes every buffered position to the memory array through a simple write port. It raises `busy` for a fixed number of clock cycles. The front-end uses `busy` to withhold every acknowledge, so a master finds the end of the cycle by polling with its device address.

While `busy` is high, every input strobe is ignored. A start condition opens a new transfer and discards anything buffered and not yet committed.

Top module: `pagewr_engine`

## Requirements
- R1: After reset `busy` and `memWe` are low and no memory write takes place.
- R2: A byte accepted on `byteValid` is stored for the position whose upper address bits (`addrIn[ADDR_W-1:4]`) come from the last `addrLoad`. Its lower 4 bits come from the in-page pointer, which is loaded from `addrIn[3:0]` and then increases by one after each byte. The upper bits never change because of a byte.
- R3: When the in-page pointer is at offset 15, the next byte goes to offset 0 of the same page row.
- R4: When more than 16 bytes are sent in one transfer, each page position ends up holding the last byte sent to it.
- R5: A `stopSeen` pulse with at least one buffered byte sets `busy` at the next clock edge. `busy` then stays high for exactly `WR_CYCLES` clock cycles.
- R6: Each position written in the transfer is committed by exactly one `memWe` cycle. Every `memWe` cycle lies inside the busy window.
- R7: Array positions not written in the transfer keep their earlier contents.
- R8: A `stopSeen` with nothing buffered starts no cycle, and `busy` stays low. This covers a stop right after `addrLoad`, and a stop after a `startSeen` that followed data bytes.
- R9: While `busy` is high, `startSeen`, `addrLoad`, `byteValid` and `stopSeen` have no effect. They cause no extra memory writes, do not change the busy length, and do not affect the next transfer.
- R10: After `busy` falls, a new transfer is accepted and committed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startSeen | input | 1 | One-cycle strobe: start condition seen, new transfer |
| addrLoad | input | 1 | One-cycle strobe: load the word address from `addrIn` |
| addrIn | input | ADDR_W | Word address of the first data byte |
| byteValid | input | 1 | One-cycle strobe: `byteData` holds a received data byte |
| byteData | input | DATA_W | Received data byte |
| stopSeen | input | 1 | One-cycle strobe: stop condition seen |
| memWe | output | 1 | Array write enable |
| memAddr | output | ADDR_W | Array write address |
| memWdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming cycle running; acknowledges must be withheld |

## Verification
`busy` is registered and goes high at the clock edge that samples `stopSeen`. The bench drives strobes on falling edges. It reads `busy` at the falling edge right after the stop strobe is removed, then counts falling edges while `busy` is high and expects `WR_CYCLES`. The array writes come from registers during the first 16 cycles of the window. The bench compares its memory model with the expected image only after `busy` has fallen, so it never samples in the middle of a commit. For empty stops, `busy` is checked on several falling edges after the stop.

// File: rtl/pagewr_pkg.sv
package pagewr_pkg;

  // Strobes the control issues to the datapath, one cycle each.
  typedef struct packed {
    logic clearFill;    // new transfer: drop buffered bytes
    logic loadAddr;     // capture row and in-page pointer
    logic storeByte;    // write byte at pointer, advance pointer
    logic beginCommit;  // start walking the buffer into the array
  } pwStrobes_t;

endpackage

// File: rtl/pagewr_ctrl.sv
module pagewr_ctrl
  import pagewr_pkg::*;
#(
  parameter int WR_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startSeen,
  input  logic       addrLoad,
  input  logic       byteValid,
  input  logic       stopSeen,
  input  logic       anyFilled,
  output pwStrobes_t strobes,
  output logic       busy
);

  localparam int TMR_W = $clog2(WR_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WR_CYCLES - 1);

  typedef enum logic {ST_OPEN, ST_PROGRAM} pwState_t;

  pwState_t   state;
  logic [TMR_W-1:0] timer;
  logic       accepting;

  assign accepting = (state == ST_OPEN);
  assign busy      = (state == ST_PROGRAM);

  always_comb begin
    strobes             = '0;
    strobes.clearFill   = accepting & startSeen;
    strobes.loadAddr    = accepting & addrLoad;
    strobes.storeByte   = accepting & byteValid;
    strobes.beginCommit = accepting & stopSeen & anyFilled;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_OPEN;
      timer <= '0;
    end else begin
      case (state)
        ST_OPEN: begin
          if (strobes.beginCommit) begin
            state <= ST_PROGRAM;
            timer <= TMR_LOAD;
          end
        end
        ST_PROGRAM: begin
          if (timer == '0) begin
            state <= ST_OPEN;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= ST_OPEN;
      endcase
    end
  end

  // R5: a programming cycle only ever begins right after a stop strobe.
  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopSeen));

  // R8: a stop with nothing buffered leaves the engine idle.
  assert_no_empty_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopSeen && !anyFilled) |=> !busy);

  // R9: a stop seen while busy does not restart the timer.
  assert_stop_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stopSeen && timer != TMR_LOAD) |=> (timer != TMR_LOAD));

endmodule

// File: rtl/pagewr_datapath.sv
module pagewr_datapath
  import pagewr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobes_t        strobes,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] byteData,
  output logic              anyFilled,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int ROW_W = ADDR_W - OFS_W;
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1);

  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] fillMask;
  logic [PAGE_BYTES-1:0] fillNext;
  logic [ROW_W-1:0]      pageRow;
  logic [OFS_W-1:0]      wrOfs;
  logic [OFS_W-1:0]      commitIdx;
  logic                  commitOn;

  // One storage slot per page position.
  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.storeByte && wrOfs == OFS_W'(s)) begin
        pageBuf[s] <= byteData;
      end
    end
  end

  // Fill mask: set on store, cleared by a new transfer or by committing.
  always_comb begin
    fillNext = fillMask;
    if (strobes.clearFill) begin
      fillNext = '0;
    end
    if (commitOn) begin
      fillNext[commitIdx] = 1'b0;
    end
    if (strobes.storeByte) begin
      fillNext[wrOfs] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillMask <= '0;
    end else begin
      fillMask <= fillNext;
    end
  end

  // Row and in-page pointer; only the pointer moves, modulo the page.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageRow <= '0;
      wrOfs   <= '0;
    end else if (strobes.loadAddr) begin
      pageRow <= addrIn[ADDR_W-1:OFS_W];
      wrOfs   <= addrIn[OFS_W-1:0];
    end else if (strobes.storeByte) begin
      wrOfs <= wrOfs + 1'b1;
    end
  end

  // Commit walk: one page position per cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitOn  <= 1'b0;
      commitIdx <= '0;
    end else if (strobes.beginCommit) begin
      commitOn  <= 1'b1;
      commitIdx <= '0;
    end else if (commitOn) begin
      commitIdx <= commitIdx + 1'b1;
      if (commitIdx == LAST_OFS) begin
        commitOn <= 1'b0;
      end
    end
  end

  assign anyFilled = |fillMask;
  assign memWe     = commitOn & fillMask[commitIdx];
  assign memAddr   = {pageRow, commitIdx};
  assign memWdata  = pageBuf[commitIdx];

  // R2: storing a byte never moves the page row.
  assert_row_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.storeByte && !strobes.loadAddr) |=> $stable(pageRow));

  // R3: the pointer wraps to the start of the same page.
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.storeByte && !strobes.loadAddr && wrOfs == LAST_OFS) |=> (wrOfs == '0));

  // R6: the array is only written inside the busy window.
  assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R6: by the end of the window every buffered position has been committed.
  assert_drained_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !anyFilled);

endmodule

// File: rtl/pagewr_engine.sv
module pagewr_engine
  import pagewr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeen,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stopSeen,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              busy
);

  pwStrobes_t strobes;
  logic       anyFilled;

  pagewr_ctrl #(
    .WR_CYCLES(WR_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startSeen(startSeen),
    .addrLoad (addrLoad),
    .byteValid(byteValid),
    .stopSeen (stopSeen),
    .anyFilled(anyFilled),
    .strobes  (strobes),
    .busy     (busy)
  );

  pagewr_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busy     (busy),
    .addrIn   (addrIn),
    .byteData (byteData),
    .anyFilled(anyFilled),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  // R1: nothing is written while the engine is idle.
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWe);

endmodule

// File: tb/test_pagewr_engine.sv
module test_pagewr_engine;

  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int PAGE   = 16;
  localparam int WRC    = 40;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startSeen = 1'b0;
  logic              addrLoad = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              byteValid = 1'b0;
  logic [DATA_W-1:0] byteData = '0;
  logic              stopSeen = 1'b0;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              busy;

  int checks = 0;
  int errors = 0;
  int weCount = 0;
  int weStray = 0;
  logic [DATA_W-1:0] arrMem [DEPTH];
  logic [DATA_W-1:0] expMem [DEPTH];

  always #10 clk = ~clk;

  pagewr_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .WR_CYCLES(WRC)
  ) i_pagewr_engine (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .addrLoad(addrLoad),
    .addrIn(addrIn), .byteValid(byteValid), .byteData(byteData),
    .stopSeen(stopSeen), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .busy(busy)
  );

  // Array model fed by the write port.
  always @(posedge clk) begin
    if (memWe) begin
      arrMem[memAddr] <= memWdata;
      weCount = weCount + 1;
      if (!busy) weStray = weStray + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkArray(input string req);
    int bad = 0;
    int firstA = -1;
    for (int a = 0; a < DEPTH; a++) begin
      if (arrMem[a] !== expMem[a]) begin
        bad++;
        if (firstA < 0) firstA = a;
      end
    end
    if (firstA < 0) check(1'b1, req, 0, 0);
    else check(1'b0, {req, " array byte"}, int'(arrMem[firstA]), int'(expMem[firstA]));
  endtask

  task automatic idleInputs();
    startSeen = 1'b0; addrLoad = 1'b0; byteValid = 1'b0; stopSeen = 1'b0;
  endtask

  // One transfer: start, address, n bytes, optional aborting start, stop.
  task automatic runTransfer(input int addr, input int n, input bit abortIt,
                             input bit noise, input string tag);
    logic [PAGE-1:0] touched = '0;
    int ofs = addr % PAGE;
    int row = addr / PAGE;
    int len = 0;
    int expWe;
    weCount = 0;
    weStray = 0;
    @(negedge clk); startSeen = 1'b1;
    @(negedge clk); startSeen = 1'b0; addrLoad = 1'b1; addrIn = ADDR_W'(addr);
    @(negedge clk); addrLoad = 1'b0;
    for (int k = 0; k < n; k++) begin
      byteValid = 1'b1;
      byteData  = DATA_W'($urandom);
      if (!abortIt) begin
        expMem[row * PAGE + ofs] = byteData;
        touched[ofs] = 1'b1;
      end
      ofs = (ofs + 1) % PAGE;
      @(negedge clk);
    end
    byteValid = 1'b0;
    if (abortIt) begin
      startSeen = 1'b1;
      @(negedge clk); startSeen = 1'b0;
    end
    stopSeen = 1'b1;
    @(negedge clk); stopSeen = 1'b0;
    expWe = $countones(touched);
    if (expWe == 0) begin
      // R8: no cycle may start
      for (int w = 0; w < 4; w++) begin
        check(busy == 1'b0, {"R8 busy after empty stop ", tag}, int'(busy), 0);
        @(negedge clk);
      end
    end else begin
      check(busy == 1'b1, {"R5 busy after stop ", tag}, int'(busy), 1);
      while (busy) begin
        len++;
        if (noise) begin
          startSeen = 1'($urandom);
          addrLoad  = 1'($urandom);
          addrIn    = ADDR_W'($urandom);
          byteValid = 1'($urandom);
          byteData  = DATA_W'($urandom);
          stopSeen  = 1'($urandom);
        end
        @(negedge clk);
        if (len > WRC + 5) break;
      end
      idleInputs();
      check(len == WRC, {"R5 R9 busy length ", tag}, len, WRC);
    end
    check(weCount == expWe, {"R6 R9 write count ", tag}, weCount, expWe);
    check(weStray == 0, {"R6 writes outside busy ", tag}, weStray, 0);
    checkArray({"R2 R4 R7 ", tag});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int a = 0; a < DEPTH; a++) begin
      arrMem[a] = DATA_W'(a * 7 + 3);
      expMem[a] = DATA_W'(a * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(memWe == 1'b0, "R1 memWe in reset", int'(memWe), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && memWe == 1'b0, "R1 idle after reset", int'(busy), 0);

    // Directed corners
    runTransfer(32'h040, 1, 1'b0, 1'b0, "R2 single byte");
    runTransfer(32'h100, 16, 1'b0, 1'b0, "R2 full page");
    runTransfer(32'h23F, 3, 1'b0, 1'b0, "R3 wrap from 15");
    runTransfer(32'h305, 20, 1'b0, 1'b0, "R4 overrun 20");
    runTransfer(32'h3A0, 35, 1'b0, 1'b0, "R4 overrun 35");
    runTransfer(32'h500, 0, 1'b0, 1'b0, "R8 no data");
    runTransfer(32'h510, 4, 1'b1, 1'b0, "R8 start after data");
    runTransfer(32'h512, 2, 1'b0, 1'b0, "R8 R10 after abort");
    runTransfer(32'h600, 16, 1'b0, 1'b1, "R9 noise while busy");
    runTransfer(32'h608, 5, 1'b0, 1'b0, "R9 R10 after noise");

    // Random transfers
    for (int t = 0; t < 40; t++) begin
      runTransfer(int'($urandom % DEPTH), int'($urandom % 40), 1'b0,
                  1'($urandom), "R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule